// File: doc/BRIEF.md
# Interrupt Status Word Register

This block holds the 16-bit status word that a network controller shows to the host processor. The upper byte collects eight interrupt causes. Each cause stays set until software clears it by writing a 1 to its position. The lower byte gives the live state of the command unit and the receive unit as read-only codes. The block also drives one interrupt request line, which stays high while any cause is pending.

Six causes come straight from single-cycle event pulses. The other two come from the unit state codes. The not-active cause follows command-unit transitions, and a mode input selects which transition sets it. The receive-not-ready cause follows the receive unit leaving its ready condition. The command-unit and receive-unit codes pass through a register before they reach the read port. A read therefore returns a stable value, and the same registered copy serves as the previous state for edge detection.

Top module: `irq_status_word`

## Requirements
- R1: While reset is asserted, and after it is released with quiet inputs, the word reads 0000h and `irq_o` is low.
- R2: A pulse on a direct event input sets its cause bit on the next clock edge, and the bit then stays 1. The bit positions are: command done on bit 15, frame received on bit 14, software interrupt on bit 10, early receive on bit 9, and flow-control pause on bit 8.
- R3: A write with `wr_en_i` high clears each cause bit (15:8) whose `wr_data_i` bit is 1. Cause bits whose `wr_data_i` bit is 0 keep their value.
- R4: If a set event and a write-1 clear reach the same cause bit on the same edge, the bit ends up 1.
- R5: With `cu_idle_only_i` = 0, bit 13 sets when the registered command-unit code is active (10 or 11) and the sampled code is 00 or 01. Moves between 00 and 01 do not set it.
- R6: With `cu_idle_only_i` = 1, bit 13 sets only when the registered command-unit code is not 00 and the sampled code is 00. A move from active to 01 does not set it.
- R7: Bit 12 sets when the registered receive-unit code is a ready code (0100 or 1100) and the sampled code is not a ready code. A move between the two ready codes does not set it.
- R8: Bit 11 sets on a management-cycle done pulse only while `mdio_irq_en_i` is 1.
- R9: Bits 7:6 read the command-unit code and bits 5:2 read the receive-unit code. Each code appears one clock edge after it is sampled.
- R10: Bits 1:0 always read 0. Writes to bits 7:0 have no effect on the word.
- R11: `irq_o` is 1 exactly when at least one of bits 15:8 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cu_state_i | input | 2 | Command-unit state code (00 idle, 01 suspended, 10/11 active) |
| ru_state_i | input | 4 | Receive-unit state code (0100 and 1100 ready) |
| cu_idle_only_i | input | 1 | 0: not-active cause on leaving active; 1: only on entering idle |
| ev_cmd_done_i | input | 1 | Command-completed pulse |
| ev_frame_rx_i | input | 1 | Frame-received pulse |
| ev_mdio_done_i | input | 1 | Management-cycle done pulse |
| mdio_irq_en_i | input | 1 | Enable for the management-cycle cause |
| ev_sw_irq_i | input | 1 | Software interrupt pulse |
| ev_early_rx_i | input | 1 | Early-receive pulse |
| ev_pause_i | input | 1 | Flow-control pause pulse |
| wr_en_i | input | 1 | Write strobe from the host port |
| wr_data_i | input | 16 | Write data; 1s in bits 15:8 clear causes |
| rd_data_o | output | 16 | Current status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that the state codes and event inputs are synchronous to `clk_i` and change only between edges. They also assume that a reserved receive-unit code counts as "not ready" like any other non-ready code. The stimulus drives every input just after the falling edge and holds it for a whole cycle. Pulses last one cycle. A random phase that draws from all codes, reserved ones included, runs under both mode settings, so all state transitions are reached while the inputs keep to the synchronous assumption.

// File: rtl/isw_pkg.sv
package isw_pkg;
  localparam int unsigned CAUSE_W = 8;
  localparam int unsigned CU_W    = 2;
  localparam int unsigned RU_W    = 4;
  localparam int unsigned RSV_W   = 2;
  localparam int unsigned WORD_W  = CAUSE_W + CU_W + RU_W + RSV_W;

  // cause bit offsets within the upper byte
  localparam int unsigned C_CMD   = 7;
  localparam int unsigned C_FRAME = 6;
  localparam int unsigned C_CUNA  = 5;
  localparam int unsigned C_RUNR  = 4;
  localparam int unsigned C_MDIO  = 3;
  localparam int unsigned C_SW    = 2;
  localparam int unsigned C_ERX   = 1;
  localparam int unsigned C_PAUSE = 0;

  typedef enum logic [CU_W-1:0] {
    CU_IDLE = 2'b00,
    CU_SUSP = 2'b01,
    CU_LOWQ = 2'b10,
    CU_HIQ  = 2'b11
  } cu_code_e;

  localparam logic [RU_W-1:0] RU_READY      = 4'b0100;
  localparam logic [RU_W-1:0] RU_READY_NOBD = 4'b1100;

  function automatic logic cu_active(input logic [CU_W-1:0] s);
    return s[CU_W-1];
  endfunction

  function automatic logic cu_idle(input logic [CU_W-1:0] s);
    return (s == CU_IDLE);
  endfunction

  function automatic logic ru_ready(input logic [RU_W-1:0] s);
    return (s == RU_READY) || (s == RU_READY_NOBD);
  endfunction
endpackage

// File: rtl/isw_state_track.sv
module isw_state_track
  import isw_pkg::*;
#(
  parameter int unsigned CUW = CU_W,
  parameter int unsigned RUW = RU_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CUW-1:0] cu_i,
  input  logic [RUW-1:0] ru_i,
  input  logic           idle_only_i,
  output logic [CUW-1:0] cu_q_o,
  output logic [RUW-1:0] ru_q_o,
  output logic           cu_evt_o,
  output logic           ru_evt_o
);
  logic [CUW-1:0] cu_q, cu_d;
  logic [RUW-1:0] ru_q, ru_d;
  logic           cu_en, ru_en;
  logic           leave_active, enter_idle;

  always_comb begin
    cu_en = (cu_i != cu_q);
    ru_en = (ru_i != ru_q);
    cu_d  = cu_i;
    ru_d  = ru_i;
  end

  always_comb begin
    leave_active = cu_active(cu_q) && !cu_active(cu_i);
    enter_idle   = !cu_idle(cu_q) && cu_idle(cu_i);
    cu_evt_o     = idle_only_i ? enter_idle : leave_active;
    ru_evt_o     = ru_ready(ru_q) && !ru_ready(ru_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cu_q <= '0;
    end else if (cu_en) begin
      cu_q <= cu_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ru_q <= '0;
    end else if (ru_en) begin
      ru_q <= ru_d;
    end
  end

  assign cu_q_o = cu_q;
  assign ru_q_o = ru_q;
endmodule

// File: rtl/isw_cause_bank.sv
module isw_cause_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic         any_o
);
  logic [W-1:0] q, d, en;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      en[i] = set_i[i] | clr_i[i];
      d[i]  = set_i[i];   // set takes priority over clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q[i] <= 1'b0;
      end else if (en[i]) begin
        q[i] <= d[i];
      end
    end
  end

  assign q_o   = q;
  assign any_o = |q;
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
  import isw_pkg::*;
#(
  parameter int unsigned NCAUSE = CAUSE_W,
  parameter int unsigned CUW    = CU_W,
  parameter int unsigned RUW    = RU_W,
  localparam int unsigned WW    = NCAUSE + CUW + RUW + RSV_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [CUW-1:0] cu_state_i,
  input  logic [RUW-1:0] ru_state_i,
  input  logic           cu_idle_only_i,
  input  logic           ev_cmd_done_i,
  input  logic           ev_frame_rx_i,
  input  logic           ev_mdio_done_i,
  input  logic           mdio_irq_en_i,
  input  logic           ev_sw_irq_i,
  input  logic           ev_early_rx_i,
  input  logic           ev_pause_i,
  input  logic           wr_en_i,
  input  logic [WW-1:0]  wr_data_i,
  output logic [WW-1:0]  rd_data_o,
  output logic           irq_o
);
  localparam int unsigned CAUSE_LSB = WW - NCAUSE;

  logic [CUW-1:0]    cu_q;
  logic [RUW-1:0]    ru_q;
  logic              cu_evt, ru_evt;
  logic [NCAUSE-1:0] set_vec, clr_vec, cause_q;
  logic              any_cause;

  isw_state_track #(.CUW(CUW), .RUW(RUW)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cu_i        (cu_state_i),
    .ru_i        (ru_state_i),
    .idle_only_i (cu_idle_only_i),
    .cu_q_o      (cu_q),
    .ru_q_o      (ru_q),
    .cu_evt_o    (cu_evt),
    .ru_evt_o    (ru_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[C_CMD]   = ev_cmd_done_i;
    set_vec[C_FRAME] = ev_frame_rx_i;
    set_vec[C_CUNA]  = cu_evt;
    set_vec[C_RUNR]  = ru_evt;
    set_vec[C_MDIO]  = ev_mdio_done_i & mdio_irq_en_i;
    set_vec[C_SW]    = ev_sw_irq_i;
    set_vec[C_ERX]   = ev_early_rx_i;
    set_vec[C_PAUSE] = ev_pause_i;
    clr_vec          = wr_en_i ? wr_data_i[WW-1:CAUSE_LSB] : '0;
  end

  isw_cause_bank #(.W(NCAUSE)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .q_o    (cause_q),
    .any_o  (any_cause)
  );

  assign rd_data_o = {cause_q, cu_q, ru_q, {RSV_W{1'b0}}};
  assign irq_o     = any_cause;
endmodule

// File: rtl/isw_checker.sv
module isw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  cu_state_i,
  input logic [3:0]  ru_state_i,
  input logic        cu_idle_only_i,
  input logic        ev_cmd_done_i,
  input logic        ev_frame_rx_i,
  input logic        ev_mdio_done_i,
  input logic        mdio_irq_en_i,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        irq_o
);
  logic prev_rdy, next_rdy;
  assign prev_rdy = (rd_data_o[5:2] == 4'b0100) || (rd_data_o[5:2] == 4'b1100);
  assign next_rdy = (ru_state_i == 4'b0100) || (ru_state_i == 4'b1100);

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_data_o == 16'h0000));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_cmd_done_i |=> rd_data_o[15]);

  a_r3_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[14] && !ev_frame_rx_i) |=> !rd_data_o[14]);

  a_r5_leave_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cu_idle_only_i && rd_data_o[7] && !cu_state_i[1]) |=> rd_data_o[13]);

  a_r6_enter_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cu_idle_only_i && (rd_data_o[7:6] != 2'b00) && (cu_state_i == 2'b00)) |=> rd_data_o[13]);

  a_r7_leave_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_rdy && !next_rdy) |=> rd_data_o[12]);

  a_r8_mdio_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[11]) |-> $past(ev_mdio_done_i && mdio_irq_en_i));

  a_r9_fields_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rd_data_o[7:2] == $past({cu_state_i, ru_state_i})));

  a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[1:0] == 2'b00);

  a_r11_irq_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rd_data_o[15:8] != 8'h00));
endmodule

bind irq_status_word isw_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cu_state_i     (cu_state_i),
  .ru_state_i     (ru_state_i),
  .cu_idle_only_i (cu_idle_only_i),
  .ev_cmd_done_i  (ev_cmd_done_i),
  .ev_frame_rx_i  (ev_frame_rx_i),
  .ev_mdio_done_i (ev_mdio_done_i),
  .mdio_irq_en_i  (mdio_irq_en_i),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .rd_data_o      (rd_data_o),
  .irq_o          (irq_o)
);

// File: tb/irq_status_word_test.sv
`timescale 1ns/1ps
module irq_status_word_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cu = 2'b00;
  logic [3:0]  ru = 4'b0000;
  logic        idle_only = 1'b0;
  logic        e_cmd = 0, e_frm = 0, e_mdio = 0, mdio_en = 0, e_sw = 0, e_erx = 0, e_pause = 0;
  logic        wen = 0;
  logic [15:0] wdat = '0;
  logic [15:0] rd;
  logic        irq;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_status_word uut (
    .clk_i(clk), .rst_ni(rst_n), .cu_state_i(cu), .ru_state_i(ru),
    .cu_idle_only_i(idle_only), .ev_cmd_done_i(e_cmd), .ev_frame_rx_i(e_frm),
    .ev_mdio_done_i(e_mdio), .mdio_irq_en_i(mdio_en), .ev_sw_irq_i(e_sw),
    .ev_early_rx_i(e_erx), .ev_pause_i(e_pause), .wr_en_i(wen),
    .wr_data_i(wdat), .rd_data_o(rd), .irq_o(irq)
  );

  // behavioural reference model
  int m_cause = 0;
  int m_cu = 0;
  int m_ru = 0;

  function automatic bit is_rdy(int r);
    return (r == 4) || (r == 12);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause = 0; m_cu = 0; m_ru = 0;
    end else begin
      int s;
      int c;
      s = 0;
      c = int'(cu);
      if (e_cmd)   s += 128;
      if (e_frm)   s += 64;
      if (!idle_only && m_cu >= 2 && c < 2) s += 32;
      if (idle_only && m_cu != 0 && c == 0) s += 32;
      if (is_rdy(m_ru) && !is_rdy(int'(ru))) s += 16;
      if (e_mdio && mdio_en) s += 8;
      if (e_sw)    s += 4;
      if (e_erx)   s += 2;
      if (e_pause) s += 1;
      if (wen) m_cause = m_cause & ~int'(wdat[15:8]);
      m_cause = m_cause | s;
      m_cu = c;
      m_ru = int'(ru);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(rd[15:8]) == m_cause, "R2-R8 cause byte", int'(rd[15:8]), m_cause);
      chk(int'(rd[7:2]) == m_cu * 16 + m_ru, "R9 state fields", int'(rd[7:2]), m_cu * 16 + m_ru);
      chk(rd[1:0] == 2'b00, "R10 reserved", int'(rd[1:0]), 0);
      chk(irq == (m_cause != 0), "R11 irq", int'(irq), int'(m_cause != 0));
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    wen = 1; wdat = d; cyc(); wen = 0; wdat = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd == 16'h0000 && !irq, "R1 in reset", int'(rd), 0);
    rst_n = 1;
    cyc();
    chk(rd == 16'h0000 && !irq, "R1 after release", int'(rd), 0);

    // R2 direct causes
    e_cmd = 1; cyc(); e_cmd = 0;
    chk(rd[15] == 1, "R2 cmd bit15", int'(rd[15]), 1);
    cyc();
    chk(rd[15] == 1, "R2 cmd latched", int'(rd[15]), 1);
    chk(irq == 1, "R11 irq high", int'(irq), 1);
    e_frm = 1; e_sw = 1; e_erx = 1; e_pause = 1; cyc();
    e_frm = 0; e_sw = 0; e_erx = 0; e_pause = 0;
    chk(rd[15:8] == 8'hC7, "R2 multi causes", int'(rd[15:8]), 'hC7);

    // R3 write-1-to-clear
    wr(16'h4100);
    chk(rd[15:8] == 8'h86, "R3 partial clear", int'(rd[15:8]), 'h86);
    wr(16'h0000);
    chk(rd[15:8] == 8'h86, "R3 zero write keeps", int'(rd[15:8]), 'h86);
    wr(16'hFF00);
    chk(rd[15:8] == 8'h00 && !irq, "R3 clear all / R11", int'(rd[15:8]), 0);

    // R4 set wins over clear
    e_sw = 1; wen = 1; wdat = 16'h0400; cyc(); e_sw = 0; wen = 0; wdat = '0;
    chk(rd[10] == 1, "R4 set wins", int'(rd[10]), 1);
    wr(16'hFF00);

    // R8 management cause gated
    mdio_en = 0; e_mdio = 1; cyc(); e_mdio = 0;
    chk(rd[11] == 0, "R8 disabled", int'(rd[11]), 0);
    mdio_en = 1; e_mdio = 1; cyc(); e_mdio = 0;
    chk(rd[11] == 1, "R8 enabled", int'(rd[11]), 1);
    wr(16'hFF00);

    // R5 leave-active mode
    idle_only = 0;
    cu = 2'b10; cyc();
    chk(rd[7:6] == 2'b10 && rd[13] == 0, "R9 cu field / R5 enter active", int'(rd[7:6]), 2);
    cu = 2'b01; cyc();
    chk(rd[13] == 1, "R5 active to suspended", int'(rd[13]), 1);
    wr(16'hFF00);
    cu = 2'b00; cyc();
    chk(rd[13] == 0, "R5 suspended to idle no set", int'(rd[13]), 0);

    // R6 idle-only mode
    idle_only = 1;
    cu = 2'b11; cyc(); cu = 2'b01; cyc();
    chk(rd[13] == 0, "R6 active to suspended no set", int'(rd[13]), 0);
    cu = 2'b00; cyc();
    chk(rd[13] == 1, "R6 enter idle", int'(rd[13]), 1);
    wr(16'hFF00);

    // R7 receive leaves ready
    ru = 4'b0100; cyc();
    chk(rd[5:2] == 4'b0100 && rd[12] == 0, "R9 ru field / R7", int'(rd[5:2]), 4);
    ru = 4'b1100; cyc();
    chk(rd[12] == 0, "R7 ready to ready", int'(rd[12]), 0);
    ru = 4'b1010; cyc();
    chk(rd[12] == 1, "R7 leave ready", int'(rd[12]), 1);

    // R10 low-byte writes ignored
    wr(16'h00FF);
    chk(rd == 16'h1028, "R10 low write ignored", int'(rd), 'h1028);
    wr(16'hFF00);

    // random phase, compared each cycle by the model
    for (int i = 0; i < 2000; i++) begin
      cu = 2'($urandom); ru = 4'($urandom);
      idle_only = (i >= 1000);
      e_cmd = ($urandom % 4) == 0; e_frm = ($urandom % 4) == 0;
      e_mdio = ($urandom % 3) == 0; mdio_en = $urandom % 2;
      e_sw = ($urandom % 5) == 0; e_erx = ($urandom % 5) == 0; e_pause = ($urandom % 5) == 0;
      wen = $urandom % 2; wdat = 16'($urandom);
      cyc();
    end
    e_cmd = 0; e_frm = 0; e_mdio = 0; e_sw = 0; e_erx = 0; e_pause = 0; wen = 0;
    cyc();
    finish_run();
  end
endmodule